// File: doc/BRIEF.md
# Line Polarity Inversion Detector

This block sits beside a frame synchronizer on a two-wire receive line. It watches the received serial bit stream through an eight-bit sliding window. It classifies each window as a match to one of two reference sync patterns, as a match to the bitwise complement of one of them, or as no match. The two wires of the pair may have been swapped at installation. When that happens every received symbol arrives with its polarity reversed, so the synchronizer locks onto the complemented pattern.

The block does not run the sync search. It only reads the synchronizer's state code. On the single cycle where that state moves directly from out-of-sync to locked, it latches whether the lock was on a normal or a complemented pattern. That latched flag is visible to software. The same flag also drives an automatic fix on the parallel receive samples: while the flag is set, the sign bit (MSB) of every valid sample is complemented on its way out, and all other bits pass through unchanged.

Top module: `line_polarity_detector`

## Requirements
- R1: After reset, `inv_flag`, `samp_out_vld` and `samp_out` are all 0.
- R2: On each cycle with `rx_bit_en` high, `rx_bit` is shifted into the eight-bit window at the LSB end, so the oldest of the last eight accepted bits sits in the MSB. With `rx_bit_en` low, the window holds. The window is compared against `pat_a`, `pat_b`, `~pat_a` and `~pat_b`.
- R3: `sync_state` codes are 0 = out of sync, 1 = hunting/verifying, 2 = locked, 3 = reserved. A lock event is a clock edge where the previously registered state was 0 and the present state is 2. The registered state starts at 0 after reset. No other transition, including 1→2 and 3→2, counts as a lock event.
- R4: At a lock event, `inv_flag` becomes 0 if the window matches a normal pattern and 1 if it matches only a complemented pattern. If the window matches nothing at that edge, the flag takes the class of the most recent earlier matching window since reset, or 0 if there has been none.
- R5: When a window equals both a normal pattern and a complemented one (for example when `pat_b == ~pat_a`), it is classified as normal.
- R6: `inv_flag` changes only at a lock event. It holds through loss of sync and through every other state transition.
- R7: A valid input sample appears on `samp_out` one cycle later, with `samp_out_vld` high. Its bit 7 is XORed with the `inv_flag` value held before that edge, and bits 6:0 are unchanged. `samp_out_vld` follows `samp_in_vld` with one cycle of delay.
- R8: While `samp_in_vld` is low, `samp_out` holds its previous value.
- R9: A sample accepted on the same edge as a lock event is corrected with the flag value from before the lock. Only the following samples use the newly latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_en | input | 1 | Shift enable for `rx_bit` |
| sync_state | input | 2 | Synchronizer state code (0 out, 1 hunt, 2 locked, 3 reserved) |
| pat_a | input | 8 | First reference sync pattern |
| pat_b | input | 8 | Second reference sync pattern |
| samp_in | input | 8 | Received parallel sample, MSB is sign |
| samp_in_vld | input | 1 | Sample valid |
| samp_out | output | 8 | Polarity-corrected sample |
| samp_out_vld | output | 1 | Corrected sample valid |
| inv_flag | output | 1 | 1 = lock gained on complemented pattern |

## Verification
The two functions that can meet on one edge are the flag update at a lock event and the sign correction of a sample accepted on that same edge. The bench provokes this in two ways. A directed step presents a valid sample together with the 0→2 state change while the window holds a pattern of the opposite class to the current flag. The random phase also produces this case many times. The result is judged at the ports: the sample must carry the old flag's correction, `inv_flag` must show the new value, and the next sample must carry the new correction.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  typedef enum logic [1:0] {
    SYNC_LOST   = 2'd0,
    SYNC_HUNT   = 2'd1,
    SYNC_LOCKED = 2'd2,
    SYNC_RSVD   = 2'd3
  } sync_st_e;
endpackage

// File: rtl/lpi_window.sv
module lpi_window #(
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_en_i,
  input  logic [PAT_W-1:0] pat_a_i,
  input  logic [PAT_W-1:0] pat_b_i,
  output logic             hit_o,
  output logic             hit_inv_o
);
  logic [PAT_W-1:0] win_q, win_d;
  logic norm_hit, comp_hit;

  always_comb begin
    win_d = win_q;
    if (bit_en_i) win_d = {win_q[PAT_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end

  always_comb begin
    norm_hit  = (win_q == pat_a_i) || (win_q == pat_b_i);
    comp_hit  = (win_q == ~pat_a_i) || (win_q == ~pat_b_i);
    hit_o     = norm_hit || comp_hit;
    hit_inv_o = comp_hit && !norm_hit;
  end

  // R2: an accepted bit lands in the window LSB
  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_en_i |=> (win_q[0] == $past(bit_i)));
  // R2: the window holds when no bit is accepted
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !bit_en_i |=> $stable(win_q));
  // R5: a complemented verdict never covers a normal match
  assert_normal_wins_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    hit_inv_o |-> (win_q != pat_a_i && win_q != pat_b_i));
endmodule

// File: rtl/lpi_lock_latch.sv
module lpi_lock_latch
  import lpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [1:0] st_i,
  input  logic       hit_i,
  input  logic       hit_inv_i,
  output logic       inv_o
);
  logic [1:0] prev_q;
  logic       last_q, last_d;
  logic       flag_q, flag_d;
  logic       lock_evt;

  always_comb begin
    lock_evt = (prev_q == SYNC_LOST) && (st_i == SYNC_LOCKED);
    last_d   = hit_i ? hit_inv_i : last_q;
    flag_d   = flag_q;
    if (lock_evt) flag_d = hit_i ? hit_inv_i : last_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= SYNC_LOST;
      last_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= st_i;
      last_q <= last_d;
      flag_q <= flag_d;
    end
  end

  assign inv_o = flag_q;

  // R6: the flag moves only on a lock event
  assert_flag_only_on_lock_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q != $past(flag_q)) |-> $past(lock_evt));
  // R4: a lock on a matching window takes that window's class
  assert_lock_class_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (lock_evt && hit_i) |=> (flag_q == $past(hit_inv_i)));
  // R3: a lock reached from hunting does not move the flag
  assert_no_lock_from_hunt_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (prev_q == SYNC_HUNT && st_i == SYNC_LOCKED) |=> $stable(flag_q));
endmodule

// File: rtl/lpi_sign_fix.sv
module lpi_sign_fix #(
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic              vld_i,
  input  logic              inv_i,
  output logic [SAMP_W-1:0] samp_o,
  output logic              vld_o
);
  localparam int MSB = SAMP_W - 1;
  logic [SAMP_W-1:0] samp_d, samp_q;
  logic              vld_q;

  always_comb begin
    samp_d = samp_q;
    if (vld_i) samp_d = {samp_i[MSB] ^ inv_i, samp_i[MSB-1:0]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      vld_q  <= vld_i;
    end
  end

  assign samp_o = samp_q;
  assign vld_o  = vld_q;

  // R7: the sign follows the flag held at acceptance, the rest passes
  assert_sign_fix_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_i |=> (samp_o[MSB] == ($past(samp_i[MSB]) ^ $past(inv_i)))
              && (samp_o[MSB-1:0] == $past(samp_i[MSB-1:0])));
  // R8: no valid input, no output change
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !vld_i |=> $stable(samp_o));
endmodule

// File: rtl/line_polarity_detector.sv
module line_polarity_detector #(
  parameter int PAT_W  = 8,
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_bit_en,
  input  logic [1:0]        sync_state,
  input  logic [PAT_W-1:0]  pat_a,
  input  logic [PAT_W-1:0]  pat_b,
  input  logic [SAMP_W-1:0] samp_in,
  input  logic              samp_in_vld,
  output logic [SAMP_W-1:0] samp_out,
  output logic              samp_out_vld,
  output logic              inv_flag
);
  logic rst_s1, rst_s2;
  logic hit, hit_inv, flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  lpi_window #(.PAT_W(PAT_W)) u_win (
    .clk(clk), .rst_ni(rst_s2), .bit_i(rx_bit), .bit_en_i(rx_bit_en),
    .pat_a_i(pat_a), .pat_b_i(pat_b), .hit_o(hit), .hit_inv_o(hit_inv)
  );

  lpi_lock_latch u_lock (
    .clk(clk), .rst_ni(rst_s2), .st_i(sync_state),
    .hit_i(hit), .hit_inv_i(hit_inv), .inv_o(flag)
  );

  lpi_sign_fix #(.SAMP_W(SAMP_W)) u_fix (
    .clk(clk), .rst_ni(rst_s2), .samp_i(samp_in), .vld_i(samp_in_vld),
    .inv_i(flag), .samp_o(samp_out), .vld_o(samp_out_vld)
  );

  assign inv_flag = flag;
endmodule

// File: tb/line_polarity_detector_test.sv
`timescale 1ns/1ps
module line_polarity_detector_test;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_bit, rx_bit_en, samp_in_vld;
  logic [1:0] sync_state;
  logic [7:0] pat_a, pat_b, samp_in, samp_out;
  logic samp_out_vld, inv_flag;

  int vectors = 0;
  int errs = 0;

  // bench model state
  logic [7:0] m_win, m_samp;
  logic [1:0] m_prev;
  logic m_last, m_flag, m_vld;

  always #4 clk = ~clk;

  line_polarity_detector uut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
    .sync_state(sync_state), .pat_a(pat_a), .pat_b(pat_b),
    .samp_in(samp_in), .samp_in_vld(samp_in_vld), .samp_out(samp_out),
    .samp_out_vld(samp_out_vld), .inv_flag(inv_flag)
  );

  // returns {hit, inverted}; normal match takes precedence (R5)
  function automatic logic [1:0] classify(input logic [7:0] w, input logic [7:0] a, input logic [7:0] b);
    logic n, c;
    n = (w == a) || (w == b);
    c = (w == ~a) || (w == ~b);
    return {n || c, c && !n};
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (inv_flag !== m_flag || samp_out_vld !== m_vld || samp_out !== m_samp) begin
      errs++;
      $display("FAIL %s: flag/vld/samp = %0b/%0b/%02h expected %0b/%0b/%02h",
               tag, inv_flag, samp_out_vld, samp_out, m_flag, m_vld, m_samp);
    end
  endtask

  task automatic step(input logic b, input logic en, input logic [1:0] st,
                      input logic [7:0] s, input logic sv, input string tag);
    logic [1:0] cl;
    rx_bit = b; rx_bit_en = en; sync_state = st; samp_in = s; samp_in_vld = sv;
    cl = classify(m_win, pat_a, pat_b);
    if (sv) m_samp = {s[7] ^ m_flag, s[6:0]};
    m_vld = sv;
    if (m_prev == 2'd0 && st == 2'd2) m_flag = cl[1] ? cl[0] : m_last;
    if (cl[1]) m_last = cl[0];
    if (en) m_win = {m_win[6:0], b};
    m_prev = st;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic push_word(input logic [7:0] w, input logic [1:0] st, input string tag);
    for (int i = 7; i >= 0; i--) step(w[i], 1'b1, st, 8'h00, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; rx_bit = 0; rx_bit_en = 0; sync_state = 2'd0;
    samp_in = 0; samp_in_vld = 0; pat_a = 8'hB4; pat_b = 8'h2D;
    m_win = 0; m_samp = 0; m_prev = 0; m_last = 0; m_flag = 0; m_vld = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after release");

    // R2/R4: shift pattern A normally, lock -> flag 0
    push_word(8'hB4, 2'd0, "R2 shift A");
    step(0, 0, 2'd2, 8'h00, 0, "R4 lock normal A");
    step(0, 0, 2'd2, 8'h85, 1, "R7 sample flag 0");
    // R6: loss of sync, complemented B in window, flag holds
    step(0, 0, 2'd0, 8'h00, 0, "R6 loss");
    push_word(~8'h2D, 2'd0, "R6 hold during shift");
    step(0, 0, 2'd2, 8'h00, 0, "R4 lock inverted B");
    step(0, 0, 2'd2, 8'h85, 1, "R7 sign flipped");
    step(0, 0, 2'd2, 8'h3C, 1, "R7 sign flipped pos");
    // R8: no valid sample, output holds
    step(0, 0, 2'd2, 8'hFF, 0, "R8 hold");
    step(1, 1, 2'd1, 8'h00, 0, "R8 hold 2");
    // R9: lock on A with sample in the same cycle
    step(0, 0, 2'd0, 8'h00, 0, "R9 prep");
    push_word(8'hB4, 2'd0, "R9 shift");
    step(0, 0, 2'd2, 8'h12, 1, "R9 same-cycle sample");
    step(0, 0, 2'd2, 8'h12, 1, "R9 next sample");
    // R3: hunt->locked and reserved->locked do not update
    push_word(~8'hB4, 2'd1, "R3 shift in hunt");
    step(0, 0, 2'd2, 8'h00, 0, "R3 1->2 no update");
    step(0, 0, 2'd3, 8'h00, 0, "R3 reserved");
    step(0, 0, 2'd2, 8'h00, 0, "R3 3->2 no update");
    // R4: lock with no match falls back to last match (inverted)
    step(0, 0, 2'd0, 8'h00, 0, "R4 prep");
    push_word(8'h4B, 2'd0, "R4 shift ~A");
    step(1, 1, 2'd0, 8'h00, 0, "R4 break match");
    step(0, 0, 2'd2, 8'h00, 0, "R4 lock fallback");
    // R5: pat_b == ~pat_a, window equals A -> normal wins
    pat_b = ~8'hB4;
    step(0, 0, 2'd0, 8'h00, 0, "R5 prep");
    push_word(8'hB4, 2'd0, "R5 shift");
    step(0, 0, 2'd2, 8'h00, 0, "R5 normal priority");
    push_word(8'h4B, 2'd0, "R5 shift comp");
    step(0, 0, 2'd0, 8'h00, 0, "R5 out");
    step(0, 0, 2'd2, 8'h00, 0, "R5 lock on ~A also B");

    // constrained random phase
    pat_a = 8'($urandom()); pat_b = 8'($urandom());
    for (int n = 0; n < 3000; n++) begin
      int r, sr;
      logic [1:0] st;
      r = $urandom_range(0, 99);
      sr = $urandom_range(0, 9);
      st = (sr < 4) ? 2'd0 : (sr < 8) ? 2'd2 : (sr < 9) ? 2'd1 : 2'd3;
      if (r < 4) begin
        case ($urandom_range(0, 3))
          0: push_word(pat_a, 2'd0, "R2 rand push");
          1: push_word(pat_b, 2'd0, "R2 rand push");
          2: push_word(~pat_a, 2'd0, "R2 rand push");
          default: push_word(~pat_b, 2'd0, "R2 rand push");
        endcase
        step(0, 0, 2'd2, 8'($urandom()), 1'($urandom()), "R9 rand lock");
      end else begin
        step(1'($urandom()), (r < 75), st, 8'($urandom()), 1'($urandom()), "R4 rand");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule